// File: doc/BRIEF.md
# Keyboard Host Reply Sequencer

This block sits between the keyboard's receive path and its serial transmitter and decides which byte goes back to the host after each event. Its events are a received host byte with its parity verdict, an overrun report from the key scanner, and the end of the power-on self-test. Each event becomes exactly one reply, or a short fixed sequence for the identify command. The reply is offered to the transmitter as a byte with a request flag, which stays up until the link reports the byte as sent.

Events that arrive while a reply is in flight are latched and served one at a time, in a fixed priority order, once the link is free again. Host bytes that are ordinary commands get an acknowledge and are passed on to the command handler through a one-cycle forward strobe. LED and typematic settings are decoded elsewhere. A copy of the last byte actually sent is kept so that a resend request can replay it. A host interrupt that arrives during an acknowledge cancels that acknowledge so the new command can be taken.

Top module: `kbd_reply_ctrl`

## Requirements
- R1: A host byte received without parity error, other than 0xEE and 0xFE, is answered with 0xFA, and in the cycle the 0xFA request rises `cmd_fwd_valid` pulses for one cycle with `cmd_fwd_byte` equal to the host byte.
- R2: A host byte 0xEE received without parity error is answered with 0xEE.
- R3: A host byte 0xFE received without parity error is answered with the value of `last_byte`, which holds the most recent byte the link completed.
- R4: A host byte received with `rx_parity_err` high is answered with 0xFE, whatever its value.
- R5: An `overrun` pulse is answered with 0xFF when `scan_set` equals 1, and with 0x00 when `scan_set` is 2 or 3.
- R6: If `host_intr` is high while a 0xFA is requested, `tx_req` is low after the next clock edge and `last_byte` keeps its value, even when `tx_done` is high in that same cycle. Host bytes that arrive afterwards are answered normally.
- R7: A `selftest_done` pulse is answered with 0xAA when `selftest_pass` is high and with 0xFC when it is low.
- R8: The identify command 0xF2 is answered with 0xFA, then 0xAB, then 0x83, each as a separate request.
- R9: Completing a replay (R3) leaves `last_byte` unchanged, so repeated 0xFE requests replay the same byte.
- R10: While `tx_req` is high and neither `tx_done` nor an abort (R6) occurs, `tx_req` stays high and `tx_byte` holds its value. After `tx_done`, `tx_req` is low for at least one cycle.
- R11: Events pending when the link becomes free are served in this order: remaining identify bytes, then the latched host byte, then the self-test result, then the overrun code.
- R12: After reset `tx_req` is low and `last_byte` reads 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a host byte was received |
| rx_byte | input | 8 | Received host byte |
| rx_parity_err | input | 1 | Received byte failed its odd-parity check |
| overrun | input | 1 | One-cycle strobe: the key buffer overflowed |
| selftest_done | input | 1 | One-cycle strobe: self-test finished |
| selftest_pass | input | 1 | Self-test outcome, valid with `selftest_done` |
| scan_set | input | 2 | Active scan code set (1, 2 or 3) |
| host_intr | input | 1 | Host is pulling the link for a new command |
| tx_done | input | 1 | Link finished sending `tx_byte` |
| tx_req | output | 1 | A reply byte is waiting to be sent |
| tx_byte | output | 8 | Reply byte |
| last_byte | output | 8 | Last byte the link completed (replay source) |
| cmd_fwd_valid | output | 1 | One-cycle strobe: command passed to the handler |
| cmd_fwd_byte | output | 8 | Command byte being passed on |

## Verification
The sharpest collision is a host interrupt that lands in the same cycle as the link's done pulse for an acknowledge. The bench raises both inputs together while 0xFA is requested and expects the abort to win: the request falls and the stored last byte keeps its earlier value. A second collision is a burst of a host byte, a self-test result and an overrun, all latched while one reply is busy. Each following done pulse is checked against the stated service order.

// File: rtl/kbd_reply_pkg.sv
package kbd_reply_pkg;
   localparam logic [7:0] K_ACK     = 8'hFA;
   localparam logic [7:0] K_ECHO    = 8'hEE;
   localparam logic [7:0] K_RESEND  = 8'hFE;
   localparam logic [7:0] K_PASS    = 8'hAA;
   localparam logic [7:0] K_FAIL    = 8'hFC;
   localparam logic [7:0] K_ID_HI   = 8'hAB;
   localparam logic [7:0] K_ID_LO   = 8'h83;
   localparam logic [7:0] K_OVR_S1  = 8'hFF;
   localparam logic [7:0] K_OVR_S23 = 8'h00;

   typedef enum logic [1:0] {SRC_ID, SRC_CMD, SRC_SELF, SRC_OVR} src_e;
   typedef enum logic [1:0] {ID_IDLE, ID_FIRST, ID_SECOND} id_e;
endpackage

// File: rtl/kbd_event_latch.sv
module kbd_event_latch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_byte,
   input  logic          rx_parity_err,
   input  logic          overrun,
   input  logic          selftest_done,
   input  logic          selftest_pass,
   input  logic          take_cmd,
   input  logic          take_self,
   input  logic          take_ovr,
   output logic          cmd_pend,
   output logic [DW-1:0] cmd_byte,
   output logic          cmd_perr,
   output logic          self_pend,
   output logic          self_pass,
   output logic          ovr_pend
);
   generate
      if (DW != 8) begin : g_bad_width
         initial $error("kbd_event_latch: DW must be 8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_pend  <= 1'b0;
         cmd_byte  <= '0;
         cmd_perr  <= 1'b0;
         self_pend <= 1'b0;
         self_pass <= 1'b0;
         ovr_pend  <= 1'b0;
      end else begin
         if (rx_valid) begin
            cmd_pend <= 1'b1;
            cmd_byte <= rx_byte;
            cmd_perr <= rx_parity_err;
         end else if (take_cmd) begin
            cmd_pend <= 1'b0;
         end
         if (selftest_done) begin
            self_pend <= 1'b1;
            self_pass <= selftest_pass;
         end else if (take_self) begin
            self_pend <= 1'b0;
         end
         if (overrun)
            ovr_pend <= 1'b1;
         else if (take_ovr)
            ovr_pend <= 1'b0;
      end
   end

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> cmd_pend && cmd_byte == $past(rx_byte));
   p_ovr_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> ovr_pend);
endmodule

// File: rtl/kbd_reply_select.sv
module kbd_reply_select
   import kbd_reply_pkg::*;
#(
   parameter int          DW        = 8,
   parameter bit          ID_ENABLE = 1'b1,
   parameter logic [7:0]  ID_CMD    = 8'hF2
) (
   input  logic          cmd_pend,
   input  logic [DW-1:0] cmd_byte,
   input  logic          cmd_perr,
   input  logic          self_pend,
   input  logic          self_pass,
   input  logic          ovr_pend,
   input  logic [1:0]    scan_set,
   input  id_e           id_state,
   input  logic [DW-1:0] last_byte,
   output logic          sel_valid,
   output src_e          sel_src,
   output logic [DW-1:0] sel_byte,
   output logic          sel_ack,
   output logic          sel_resend,
   output logic          sel_idcmd
);
   logic id_hit;

   generate
      if (ID_ENABLE) begin : g_id_on
         assign id_hit = (cmd_byte == ID_CMD);
      end else begin : g_id_off
         assign id_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      sel_valid  = 1'b1;
      sel_src    = SRC_ID;
      sel_byte   = K_ID_HI;
      sel_ack    = 1'b0;
      sel_resend = 1'b0;
      sel_idcmd  = 1'b0;
      if (id_state != ID_IDLE) begin
         sel_src  = SRC_ID;
         sel_byte = (id_state == ID_FIRST) ? K_ID_HI : K_ID_LO;
      end else if (cmd_pend) begin
         sel_src = SRC_CMD;
         if (cmd_perr) begin
            sel_byte = K_RESEND;
         end else if (cmd_byte == K_ECHO) begin
            sel_byte = K_ECHO;
         end else if (cmd_byte == K_RESEND) begin
            sel_byte   = last_byte;
            sel_resend = 1'b1;
         end else begin
            sel_byte  = K_ACK;
            sel_ack   = 1'b1;
            sel_idcmd = id_hit;
         end
      end else if (self_pend) begin
         sel_src  = SRC_SELF;
         sel_byte = self_pass ? K_PASS : K_FAIL;
      end else if (ovr_pend) begin
         sel_src  = SRC_OVR;
         sel_byte = (scan_set == 2'd1) ? K_OVR_S1 : K_OVR_S23;
      end else begin
         sel_valid = 1'b0;
      end
   end
endmodule

// File: rtl/kbd_tx_hold.sv
module kbd_tx_hold
   import kbd_reply_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [7:0]  LAST_INIT = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_intr,
   input  logic          tx_done,
   input  logic          sel_valid,
   input  src_e          sel_src,
   input  logic [DW-1:0] sel_byte,
   input  logic          sel_ack,
   input  logic          sel_resend,
   input  logic          sel_idcmd,
   input  logic [DW-1:0] sel_fwd_byte,
   output logic          launch,
   output logic          tx_req,
   output logic [DW-1:0] tx_byte,
   output logic [DW-1:0] last_byte,
   output id_e           id_state,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_byte
);
   logic cur_ack, cur_resend, cur_idcmd;
   src_e cur_src;
   logic abort;

   assign launch = !tx_req && sel_valid;
   assign abort  = tx_req && cur_ack && host_intr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_req     <= 1'b0;
         tx_byte    <= '0;
         last_byte  <= LAST_INIT;
         id_state   <= ID_IDLE;
         cur_ack    <= 1'b0;
         cur_resend <= 1'b0;
         cur_idcmd  <= 1'b0;
         cur_src    <= SRC_CMD;
         fwd_valid  <= 1'b0;
         fwd_byte   <= '0;
      end else begin
         fwd_valid <= 1'b0;
         if (tx_req) begin
            if (abort) begin
               tx_req <= 1'b0;
            end else if (tx_done) begin
               tx_req <= 1'b0;
               if (!cur_resend)
                  last_byte <= tx_byte;
               if (cur_idcmd)
                  id_state <= ID_FIRST;
               else if (cur_src == SRC_ID)
                  id_state <= (id_state == ID_FIRST) ? ID_SECOND : ID_IDLE;
            end
         end else if (sel_valid) begin
            tx_req     <= 1'b1;
            tx_byte    <= sel_byte;
            cur_ack    <= sel_ack;
            cur_resend <= sel_resend;
            cur_idcmd  <= sel_idcmd;
            cur_src    <= sel_src;
            fwd_valid  <= sel_ack;
            fwd_byte   <= sel_fwd_byte;
         end
      end
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done && !abort |=> tx_req && $stable(tx_byte));
   p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_done |=> !tx_req);
   p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !tx_req && $stable(last_byte));
   p_keep_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_done && cur_resend |=> $stable(last_byte));
   p_replay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      launch && sel_resend |=> tx_byte == $past(last_byte));
endmodule

// File: rtl/kbd_reply_ctrl.sv
module kbd_reply_ctrl
   import kbd_reply_pkg::*;
#(
   parameter int          DW        = 8,
   parameter bit          ID_ENABLE = 1'b1,
   parameter logic [7:0]  ID_CMD    = 8'hF2,
   parameter logic [7:0]  LAST_INIT = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_byte,
   input  logic          rx_parity_err,
   input  logic          overrun,
   input  logic          selftest_done,
   input  logic          selftest_pass,
   input  logic [1:0]    scan_set,
   input  logic          host_intr,
   input  logic          tx_done,
   output logic          tx_req,
   output logic [DW-1:0] tx_byte,
   output logic [DW-1:0] last_byte,
   output logic          cmd_fwd_valid,
   output logic [DW-1:0] cmd_fwd_byte
);
   generate
      if (DW != 8) begin : g_bad_width
         initial $error("kbd_reply_ctrl: DW must be 8");
      end
   endgenerate

   logic          cmd_pend, cmd_perr, self_pend, self_pass, ovr_pend;
   logic [DW-1:0] cmd_byte;
   logic          sel_valid, sel_ack, sel_resend, sel_idcmd, launch;
   src_e          sel_src;
   logic [DW-1:0] sel_byte;
   id_e           id_state;
   logic          take_cmd, take_self, take_ovr;

   assign take_cmd  = launch && sel_src == SRC_CMD;
   assign take_self = launch && sel_src == SRC_SELF;
   assign take_ovr  = launch && sel_src == SRC_OVR;

   kbd_event_latch #(.DW(DW)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
      .overrun(overrun), .selftest_done(selftest_done), .selftest_pass(selftest_pass),
      .take_cmd(take_cmd), .take_self(take_self), .take_ovr(take_ovr),
      .cmd_pend(cmd_pend), .cmd_byte(cmd_byte), .cmd_perr(cmd_perr),
      .self_pend(self_pend), .self_pass(self_pass), .ovr_pend(ovr_pend)
   );

   kbd_reply_select #(.DW(DW), .ID_ENABLE(ID_ENABLE), .ID_CMD(ID_CMD)) u_select (
      .cmd_pend(cmd_pend), .cmd_byte(cmd_byte), .cmd_perr(cmd_perr),
      .self_pend(self_pend), .self_pass(self_pass), .ovr_pend(ovr_pend),
      .scan_set(scan_set), .id_state(id_state), .last_byte(last_byte),
      .sel_valid(sel_valid), .sel_src(sel_src), .sel_byte(sel_byte),
      .sel_ack(sel_ack), .sel_resend(sel_resend), .sel_idcmd(sel_idcmd)
   );

   kbd_tx_hold #(.DW(DW), .LAST_INIT(LAST_INIT)) u_hold (
      .clk(clk), .rst_n(rst_n), .host_intr(host_intr), .tx_done(tx_done),
      .sel_valid(sel_valid), .sel_src(sel_src), .sel_byte(sel_byte),
      .sel_ack(sel_ack), .sel_resend(sel_resend), .sel_idcmd(sel_idcmd),
      .sel_fwd_byte(cmd_byte), .launch(launch),
      .tx_req(tx_req), .tx_byte(tx_byte), .last_byte(last_byte),
      .id_state(id_state), .fwd_valid(cmd_fwd_valid), .fwd_byte(cmd_fwd_byte)
   );

   p_ovr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_ovr && scan_set == 2'd1 |=> tx_req && tx_byte == K_OVR_S1);
   p_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
      launch && cmd_pend && id_state == ID_IDLE |-> take_cmd);
endmodule

// File: tb/kbd_reply_ctrl_tb.sv
module kbd_reply_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0, rx_parity_err = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       overrun = 1'b0, selftest_done = 1'b0, selftest_pass = 1'b0;
   logic [1:0] scan_set = 2'd2;
   logic       host_intr = 1'b0, tx_done = 1'b0;
   logic       tx_req, cmd_fwd_valid;
   logic [7:0] tx_byte, last_byte, cmd_fwd_byte;

   int checks = 0;
   int errors = 0;
   logic [7:0] model_last;

   kbd_reply_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_parity_err(rx_parity_err), .overrun(overrun),
      .selftest_done(selftest_done), .selftest_pass(selftest_pass),
      .scan_set(scan_set), .host_intr(host_intr), .tx_done(tx_done),
      .tx_req(tx_req), .tx_byte(tx_byte), .last_byte(last_byte),
      .cmd_fwd_valid(cmd_fwd_valid), .cmd_fwd_byte(cmd_fwd_byte)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic logic [7:0] exp_reply(input logic [7:0] b, input logic perr,
                                            input logic [7:0] last);
      if (perr) return 8'hFE;
      if (b == 8'hEE) return 8'hEE;
      if (b == 8'hFE) return last;
      return 8'hFA;
   endfunction

   function automatic logic [7:0] ovr_code(input logic [1:0] s);
      return (s == 2'd1) ? 8'hFF : 8'h00;
   endfunction

   task automatic send_rx(input logic [7:0] b, input logic perr);
      rx_valid = 1'b1; rx_byte = b; rx_parity_err = perr;
      @(posedge clk); @(negedge clk);
      rx_valid = 1'b0; rx_parity_err = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic pulse_ovr(input logic [1:0] s);
      scan_set = s; overrun = 1'b1;
      @(posedge clk); @(negedge clk);
      overrun = 1'b0;
   endtask

   task automatic pulse_self(input logic pass);
      selftest_done = 1'b1; selftest_pass = pass;
      @(posedge clk); @(negedge clk);
      selftest_done = 1'b0;
   endtask

   task automatic wait_req();
      for (int i = 0; i < 20 && !tx_req; i++) @(negedge clk);
   endtask

   task automatic finish_tx();
      if (tx_req && !(tx_byte == 8'hFE && 0)) model_last = tx_byte;
      tx_done = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic expect_reply(input string req, input logic [7:0] exp);
      wait_req();
      chk({req, " req"}, {7'd0, tx_req}, 8'd1);
      chk(req, tx_byte, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
   end

   initial begin
      logic [7:0] e, b, keep;
      logic       p;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 tx_req", {7'd0, tx_req}, 8'd0);
      chk("R12 last_byte", last_byte, 8'hAA);
      model_last = 8'hAA;
      rst_n = 1'b1;
      @(negedge clk);

      // R1 acknowledge and forward strobe
      send_rx(8'h55, 1'b0);
      chk("R1 req", {7'd0, tx_req}, 8'd1);
      chk("R1 ack", tx_byte, 8'hFA);
      chk("R1 fwd_valid", {7'd0, cmd_fwd_valid}, 8'd1);
      chk("R1 fwd_byte", cmd_fwd_byte, 8'h55);
      repeat (3) @(negedge clk);
      chk("R10 held req", {7'd0, tx_req}, 8'd1);
      chk("R10 held byte", tx_byte, 8'hFA);
      finish_tx();
      chk("R10 gap", {7'd0, tx_req}, 8'd0);
      chk("R3 last updated", last_byte, 8'hFA);

      // R2 echo
      send_rx(8'hEE, 1'b0);
      expect_reply("R2", 8'hEE);
      finish_tx();

      // R3 and R9 replay, twice
      send_rx(8'hFE, 1'b0);
      expect_reply("R3", 8'hEE);
      tx_done = 1'b1; @(posedge clk); @(negedge clk); tx_done = 1'b0;
      chk("R9 last kept", last_byte, 8'hEE);
      send_rx(8'hFE, 1'b0);
      expect_reply("R9 second replay", 8'hEE);
      tx_done = 1'b1; @(posedge clk); @(negedge clk); tx_done = 1'b0;
      model_last = 8'hEE;

      // R4 parity error, even for an echo byte
      send_rx(8'hEE, 1'b1);
      expect_reply("R4", 8'hFE);
      finish_tx();

      // R5 overrun code by scan set
      for (int s = 1; s <= 3; s++) begin
         pulse_ovr(s[1:0]);
         expect_reply("R5", ovr_code(s[1:0]));
         finish_tx();
      end

      // R7 self-test outcomes
      pulse_self(1'b1);
      expect_reply("R7 pass", 8'hAA);
      finish_tx();
      pulse_self(1'b0);
      expect_reply("R7 fail", 8'hFC);
      finish_tx();

      // R8 identify sequence
      send_rx(8'hF2, 1'b0);
      expect_reply("R8 ack", 8'hFA);
      finish_tx();
      expect_reply("R8 first", 8'hAB);
      finish_tx();
      expect_reply("R8 second", 8'h83);
      finish_tx();
      @(negedge clk);
      chk("R8 done", {7'd0, tx_req}, 8'd0);

      // R6 interrupt coinciding with done during an acknowledge
      keep = last_byte;
      send_rx(8'h10, 1'b0);
      expect_reply("R6 ack", 8'hFA);
      host_intr = 1'b1; tx_done = 1'b1;
      @(posedge clk); @(negedge clk);
      host_intr = 1'b0; tx_done = 1'b0;
      chk("R6 dropped", {7'd0, tx_req}, 8'd0);
      chk("R6 last kept", last_byte, keep);
      send_rx(8'hEE, 1'b0);
      expect_reply("R6 new cmd", 8'hEE);
      finish_tx();

      // R11 service order after a busy period
      send_rx(8'h20, 1'b0);
      expect_reply("R11 busy", 8'hFA);
      pulse_ovr(2'd1);
      pulse_self(1'b1);
      send_rx(8'hEE, 1'b0);
      chk("R11 still busy", tx_byte, 8'hFA);
      finish_tx();
      expect_reply("R11 cmd first", 8'hEE);
      finish_tx();
      expect_reply("R11 selftest second", 8'hAA);
      finish_tx();
      expect_reply("R11 overrun last", 8'hFF);
      finish_tx();

      // random mix, R1 R2 R3 R4 R5 R7 R9
      for (int n = 0; n < 80; n++) begin
         int k;
         k = $urandom % 8;
         if (k == 0) begin
            logic [1:0] s;
            s = 2'($urandom % 3 + 1);
            pulse_ovr(s);
            expect_reply("R5 random", ovr_code(s));
            finish_tx();
         end else if (k == 1) begin
            p = 1'($urandom);
            pulse_self(p);
            expect_reply("R7 random", p ? 8'hAA : 8'hFC);
            finish_tx();
         end else begin
            b = 8'($urandom);
            if (k == 2) b = 8'hFE;
            if (k == 3) b = 8'hEE;
            if (b == 8'hF2) b = 8'hF3;
            p = ($urandom % 8) == 0;
            e = exp_reply(b, p, model_last);
            send_rx(b, p);
            expect_reply("R1-mix random", e);
            if (!p && b == 8'hFE) begin
               tx_done = 1'b1; @(posedge clk); @(negedge clk); tx_done = 1'b0;
               chk("R9 random last", last_byte, model_last);
            end else begin
               finish_tx();
               chk("R3 random last", last_byte, model_last);
            end
         end
      end
      report();
   end
endmodule